// File: doc/BRIEF.md
# Floppy DMA Channel Control Register File

This block holds the software-visible state of one floppy-disk DMA channel inside an I/O controller. The state is a shared DMA base address, a per-channel address pointer, a byte counter and a control/status byte. Software reaches every register through an 8-bit byte-wide port with a small offset space. A transfer engine outside the block reads the run, direction and interrupt-enable bits, and it signals a terminal count back into the block.

A control write works in two parts. The interrupt-enable and direction bits are always taken from the written byte. The remaining bits depend on bit 0. When bit 0 is set, the write is a channel reset: it stops the channel, drops the interrupt flag, reloads the address pointer at a fixed distance above the 256 KiB aligned base and zeroes the counter. When bit 0 is clear, the run bit is taken from the written byte and a one in bit 7 acknowledges the interrupt flag.

Top module: `dmach_csr`

## Requirements
- R1: After a hardware reset every register is zero: all sixteen offsets read 0x00 and run_o, dir_o, ie_o and irq_o are low.
- R2: The base address occupies offsets 0x0 to 0x3 and the address pointer occupies offsets 0x4 to 0x7. Both are big-endian: the lowest offset of each group holds bits 31:24 and the highest holds bits 7:0. The same lane mapping applies to reads and writes.
- R3: The byte counter has its high byte (bits 15:8) at offset 0x8 and its low byte (bits 7:0) at offset 0x9.
- R4: A base-address write clears bits 17:0 of the base, so those bits always read back as zero.
- R5: Every write to the control byte at offset 0xC copies bit 6 (interrupt enable, ie_o) and bit 3 (direction, dir_o) from the written value, whatever the other bits hold.
- R6: A control write with bit 0 set clears run (bit 1) and the interrupt flag (bit 7), and bit 0 itself never reads back as 1. The address pointer is loaded with base + 0x15000 and the counter is cleared.
- R7: A control write with bit 0 clear copies bit 1 into run (run_o). A 1 in bit 7 clears the interrupt flag, and a 0 in bit 7 leaves the flag unchanged.
- R8: A one-cycle pulse on tc_evt sets the interrupt flag (bit 7). If the pulse arrives in the same cycle as any clearing control write, the flag ends up set.
- R9: irq_o is high exactly while the interrupt flag and the interrupt-enable bit are both set.
- R10: The control byte reads as {flag, ie, 0, 0, dir, 0, run, 0} from bit 7 down to bit 0. Offsets 0xA, 0xB, 0xD, 0xE and 0xF read 0x00.
- R11: Software can write any address-pointer or counter byte at any time, and the write replaces whatever value a channel reset loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_wr | input | 1 | Register write strobe, one byte per cycle |
| reg_addr | input | 4 | Byte offset for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| tc_evt | input | 1 | Terminal-count pulse from the transfer engine |
| run_o | output | 1 | Channel run bit |
| dir_o | output | 1 | Transfer direction bit |
| ie_o | output | 1 | Interrupt enable bit |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a terminal-count pulse arriving in the same cycle as a control write that would clear the flag. This matters most when that write is a channel reset, because the flag, the run bit and the pointer reload all change in that one cycle. The bench drives tc_evt and the write strobe from the same falling edge, so both reach the same rising edge. It then reads the control byte and a pointer byte. To make the reload visible, the pointer byte is first overwritten with a value that differs from the reload value, which also separates reload from software override.

// File: rtl/dmach_csr_pkg.sv
package dmach_csr_pkg;
   // control/status byte bit positions
   localparam int unsigned CB_RST  = 0;
   localparam int unsigned CB_RUN  = 1;
   localparam int unsigned CB_DIR  = 3;
   localparam int unsigned CB_IE   = 6;
   localparam int unsigned CB_FLAG = 7;

   typedef struct packed {
      logic flag;
      logic ie;
      logic dir;
      logic run;
   } ctrl_t;

   function automatic logic [7:0] pack_status(ctrl_t c);
      logic [7:0] s;
      s = '0;
      s[CB_FLAG] = c.flag;
      s[CB_IE]   = c.ie;
      s[CB_DIR]  = c.dir;
      s[CB_RUN]  = c.run;
      return s;
   endfunction
endpackage

// File: rtl/dmach_lane_reg.sv
module dmach_lane_reg #(
   parameter int unsigned W        = 32,
   parameter logic [W-1:0] KEEP    = '1,
   localparam int unsigned NB      = W / 8,
   localparam int unsigned LW      = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [LW-1:0] wr_lane,
   input  logic [7:0]    wr_byte,
   input  logic          ld_en,
   input  logic [W-1:0]  ld_val,
   input  logic [LW-1:0] rd_lane,
   output logic [7:0]    rd_byte,
   output logic [W-1:0]  q
);
   if (W % 8 != 0) begin : g_bad_width
      $error("dmach_lane_reg: W must be a whole number of bytes");
   end

   logic [W-1:0] q_r;
   logic [W-1:0] nxt;

   // big-endian lanes: lane 0 is the most significant byte
   always_comb begin
      nxt = q_r;
      if (ld_en) begin
         nxt = ld_val;
      end else if (wr_en) begin
         for (int l = 0; l < int'(NB); l++) begin
            if (LW'(l) == wr_lane) nxt[W-1-8*l -: 8] = wr_byte;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= nxt & KEEP;
   end

   always_comb begin
      rd_byte = 8'h00;
      for (int l = 0; l < int'(NB); l++) begin
         if (LW'(l) == rd_lane) rd_byte = q_r[W-1-8*l -: 8];
      end
   end

   assign q = q_r;
endmodule

// File: rtl/dmach_ctrl_reg.sv
module dmach_ctrl_reg
   import dmach_csr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_byte,
   input  logic       tc_evt,
   output logic       soft_rst,
   output ctrl_t      ctrl
);
   ctrl_t c_r;
   logic  clr_flag;

   assign soft_rst = wr_en & wr_byte[CB_RST];

   always_comb begin
      clr_flag = 1'b0;
      if (wr_en) clr_flag = wr_byte[CB_RST] | wr_byte[CB_FLAG];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_r <= '0;
      end else begin
         if (wr_en) begin
            c_r.ie  <= wr_byte[CB_IE];
            c_r.dir <= wr_byte[CB_DIR];
            c_r.run <= wr_byte[CB_RST] ? 1'b0 : wr_byte[CB_RUN];
         end
         // a terminal count wins over any clear in the same cycle
         if (tc_evt)        c_r.flag <= 1'b1;
         else if (clr_flag) c_r.flag <= 1'b0;
      end
   end

   assign ctrl = c_r;
endmodule

// File: rtl/dmach_csr.sv
module dmach_csr
   import dmach_csr_pkg::*;
#(
   parameter int unsigned AW       = 32,
   parameter int unsigned CW       = 16,
   parameter int unsigned ALIGN    = 18,
   parameter logic [31:0] RELOAD   = 32'h0001_5000,
   parameter int unsigned OFS_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [OFS_W-1:0] reg_addr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   input  logic             tc_evt,
   output logic             run_o,
   output logic             dir_o,
   output logic             ie_o,
   output logic             irq_o
);
   localparam int unsigned NB_A     = AW / 8;
   localparam int unsigned NB_C     = CW / 8;
   localparam int unsigned LA       = $clog2(NB_A);
   localparam int unsigned LC       = $clog2(NB_C);
   localparam int unsigned PTR_OFS  = NB_A;
   localparam int unsigned CNT_OFS  = 2 * NB_A;
   localparam int unsigned CTRL_OFS = 2 * NB_A + 2 * NB_C;
   localparam logic [AW-1:0] BASE_KEEP = {{(AW-ALIGN){1'b1}}, {ALIGN{1'b0}}};

   if (AW % 8 != 0 || AW < 16 || AW > 32) begin : g_bad_aw
      $error("dmach_csr: AW must be 16, 24 or 32");
   end
   if (CW % 8 != 0 || CW < 16) begin : g_bad_cw
      $error("dmach_csr: CW must be a byte multiple of at least 16");
   end
   if (ALIGN >= AW) begin : g_bad_align
      $error("dmach_csr: ALIGN must be below AW");
   end
   if ((1 << OFS_W) <= CTRL_OFS) begin : g_bad_ofs
      $error("dmach_csr: OFS_W too narrow for the register map");
   end

   // offset decode
   logic in_base, in_ptr, in_cnt, in_ctrl;
   logic [LA-1:0] lane_a_base, lane_a_ptr;
   logic [LC-1:0] lane_c;

   assign in_base = reg_addr < OFS_W'(PTR_OFS);
   assign in_ptr  = (reg_addr >= OFS_W'(PTR_OFS)) && (reg_addr < OFS_W'(CNT_OFS));
   assign in_cnt  = (reg_addr >= OFS_W'(CNT_OFS)) && (reg_addr < OFS_W'(CNT_OFS + NB_C));
   assign in_ctrl = reg_addr == OFS_W'(CTRL_OFS);

   assign lane_a_base = LA'(reg_addr);
   assign lane_a_ptr  = LA'(reg_addr - OFS_W'(PTR_OFS));
   assign lane_c      = LC'(reg_addr - OFS_W'(CNT_OFS));

   logic [AW-1:0] base_q, ptr_q;
   logic [CW-1:0] cnt_q;
   logic [7:0]    rd_base, rd_ptr, rd_cnt;
   logic          soft_rst;
   ctrl_t         ctrl;
   logic [AW-1:0] reload_val;

   assign reload_val = base_q + AW'(RELOAD);

   dmach_lane_reg #(.W(AW), .KEEP(BASE_KEEP)) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr & in_base),
      .wr_lane (lane_a_base),
      .wr_byte (reg_wdata),
      .ld_en   (1'b0),
      .ld_val  ('0),
      .rd_lane (lane_a_base),
      .rd_byte (rd_base),
      .q       (base_q)
   );

   dmach_lane_reg #(.W(AW)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr & in_ptr),
      .wr_lane (lane_a_ptr),
      .wr_byte (reg_wdata),
      .ld_en   (soft_rst),
      .ld_val  (reload_val),
      .rd_lane (lane_a_ptr),
      .rd_byte (rd_ptr),
      .q       (ptr_q)
   );

   dmach_lane_reg #(.W(CW)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr & in_cnt),
      .wr_lane (lane_c),
      .wr_byte (reg_wdata),
      .ld_en   (soft_rst),
      .ld_val  ('0),
      .rd_lane (lane_c),
      .rd_byte (rd_cnt),
      .q       (cnt_q)
   );

   dmach_ctrl_reg u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr & in_ctrl),
      .wr_byte  (reg_wdata),
      .tc_evt   (tc_evt),
      .soft_rst (soft_rst),
      .ctrl     (ctrl)
   );

   logic flag_q;
   assign flag_q = ctrl.flag;

   always_comb begin
      unique case (1'b1)
         in_base: reg_rdata = rd_base;
         in_ptr:  reg_rdata = rd_ptr;
         in_cnt:  reg_rdata = rd_cnt;
         in_ctrl: reg_rdata = pack_status(ctrl);
         default: reg_rdata = 8'h00;
      endcase
   end

   assign run_o = ctrl.run;
   assign dir_o = ctrl.dir;
   assign ie_o  = ctrl.ie;
   assign irq_o = ctrl.flag & ctrl.ie;
endmodule

// File: rtl/dmach_csr_chk.sv
module dmach_csr_chk #(
   parameter int unsigned AW       = 32,
   parameter int unsigned CW       = 16,
   parameter int unsigned ALIGN    = 18,
   parameter logic [31:0] RELOAD   = 32'h0001_5000,
   parameter int unsigned OFS_W    = 4,
   parameter int unsigned CTRL_OFS = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [OFS_W-1:0] reg_addr,
   input logic [7:0]       reg_wdata,
   input logic             tc_evt,
   input logic             run_o,
   input logic             dir_o,
   input logic             ie_o,
   input logic             irq_o,
   input logic [AW-1:0]    base_q,
   input logic [AW-1:0]    ptr_q,
   input logic [CW-1:0]    cnt_q,
   input logic             flag_q
);
   logic ctrl_wr;
   assign ctrl_wr = reg_wr && (reg_addr == OFS_W'(CTRL_OFS));

   p_base_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
      base_q[ALIGN-1:0] == '0);

   p_copy_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (ie_o == $past(reg_wdata[6])) && (dir_o == $past(reg_wdata[3])));

   p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && reg_wdata[0]) |=>
         (ptr_q == $past(base_q) + AW'(RELOAD)) && (cnt_q == '0) && !run_o);

   p_run_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !reg_wdata[0]) |=> run_o == $past(reg_wdata[1]));

   p_tc_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tc_evt |=> flag_q);

   p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ie_o);

   p_irq_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_evt && ie_o && !ctrl_wr) |=> irq_o);

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> $stable(ptr_q) && $stable(cnt_q) && $stable(base_q));
endmodule

bind dmach_csr dmach_csr_chk #(
   .AW(AW), .CW(CW), .ALIGN(ALIGN), .RELOAD(RELOAD), .OFS_W(OFS_W), .CTRL_OFS(CTRL_OFS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .tc_evt    (tc_evt),
   .run_o     (run_o),
   .dir_o     (dir_o),
   .ie_o      (ie_o),
   .irq_o     (irq_o),
   .base_q    (base_q),
   .ptr_q     (ptr_q),
   .cnt_q     (cnt_q),
   .flag_q    (flag_q)
);

// File: tb/dmach_csr_tb.sv
module dmach_csr_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       tc_evt = 1'b0;
   logic       run_o, dir_o, ie_o, irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   dmach_csr u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tc_evt(tc_evt),
      .run_o(run_o), .dir_o(dir_o), .ie_o(ie_o), .irq_o(irq_o)
   );

   // row: {write?, wr offset, wr data, rd offset, expected, requirement}
   localparam int NV = 20;
   localparam logic [28:0] TBL [NV] = '{
      {1'b1, 4'h0, 8'h12, 4'h0, 8'h12, 4'd2},   // R2 base msb lane
      {1'b1, 4'h1, 8'h37, 4'h1, 8'h34, 4'd4},   // R4 bits 17:16 dropped
      {1'b1, 4'h2, 8'hFF, 4'h2, 8'h00, 4'd4},   // R4
      {1'b1, 4'h3, 8'hAB, 4'h3, 8'h00, 4'd4},   // R4
      {1'b1, 4'h4, 8'hDE, 4'h4, 8'hDE, 4'd2},   // R2 pointer msb
      {1'b1, 4'h7, 8'h55, 4'h7, 8'h55, 4'd2},   // R2 pointer lsb
      {1'b1, 4'h8, 8'hA5, 4'h8, 8'hA5, 4'd3},   // R3 count high
      {1'b1, 4'h9, 8'h3C, 4'h9, 8'h3C, 4'd3},   // R3 count low
      {1'b1, 4'hC, 8'h48, 4'hC, 8'h48, 4'd5},   // R5 ie+dir
      {1'b1, 4'hC, 8'h02, 4'hC, 8'h02, 4'd7},   // R7 run, R5 ie/dir off
      {1'b1, 4'hC, 8'h4B, 4'hC, 8'h48, 4'd6},   // R6 channel reset
      {1'b0, 4'h0, 8'h00, 4'h4, 8'h12, 4'd6},   // R6 ptr = 0x12355000
      {1'b0, 4'h0, 8'h00, 4'h5, 8'h35, 4'd6},
      {1'b0, 4'h0, 8'h00, 4'h6, 8'h50, 4'd6},
      {1'b0, 4'h0, 8'h00, 4'h7, 8'h00, 4'd6},
      {1'b0, 4'h0, 8'h00, 4'h8, 8'h00, 4'd6},   // R6 count cleared
      {1'b1, 4'h6, 8'h77, 4'h6, 8'h77, 4'd11},  // R11 override
      {1'b1, 4'h9, 8'h01, 4'h9, 8'h01, 4'd11},  // R11
      {1'b0, 4'h0, 8'h00, 4'hA, 8'h00, 4'd10},  // R10 unmapped
      {1'b0, 4'h0, 8'h00, 4'hF, 8'h00, 4'd10}   // R10 unmapped
   };

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input int req,
                      input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic tc);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; tc_evt = tc;
      @(negedge clk);
      reg_wr = 1'b0; tc_evt = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      reg_addr = a;
      #2;
      v = reg_rdata;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), v);
         chk(v, 8'h00, 1, $sformatf("R1 reset read offset %0d", a));
      end
      chk({4'h0, run_o, dir_o, ie_o, irq_o}, 8'h00, 1, "R1 reset outputs");

      for (int i = 0; i < NV; i++) begin
         logic [28:0] e;
         e = TBL[i];
         if (e[28]) wr(e[27:24], e[23:16], 1'b0);
         else @(negedge clk);
         rd(e[15:12], v);
         chk(v, e[11:4], int'(e[3:0]), $sformatf("table row %0d", i));
      end

      // R8 R9 terminal count raises flag and irq (ie=1, dir=1 here)
      @(negedge clk); tc_evt = 1'b1;
      @(negedge clk); tc_evt = 1'b0;
      rd(4'hC, v); chk(v, 8'hC8, 8, "tc sets flag");
      chk({7'd0, irq_o}, 8'h01, 9, "irq with flag and ie");

      wr(4'hC, 8'h48, 1'b0);                         // R7 bit7=0 keeps flag
      rd(4'hC, v); chk(v, 8'hC8, 7, "flag kept");

      wr(4'hC, 8'h08, 1'b0);                         // R9 ie off masks irq
      rd(4'hC, v); chk(v, 8'h88, 9, "ie cleared");
      chk({7'd0, irq_o}, 8'h00, 9, "irq masked");

      wr(4'hC, 8'hC8, 1'b0);                         // R7 write-one-to-clear
      rd(4'hC, v); chk(v, 8'h48, 7, "flag cleared");
      chk({7'd0, irq_o}, 8'h00, 9, "irq after clear");

      wr(4'hC, 8'hCA, 1'b1);                         // R8 set beats clear
      rd(4'hC, v); chk(v, 8'hCA, 8, "tc vs clear");
      chk({7'd0, run_o}, 8'h01, 7, "run_o set");

      wr(4'hC, 8'h49, 1'b1);                         // R8 R6 tc vs channel reset
      rd(4'hC, v); chk(v, 8'hC8, 8, "tc vs channel reset");
      rd(4'h6, v); chk(v, 8'h50, 6, "pointer reloaded");
      rd(4'h9, v); chk(v, 8'h00, 6, "count cleared");
      chk({6'd0, run_o, dir_o}, 8'h01, 5, "run off dir on");

      // R1 hardware reset mid-run
      @(negedge clk); rst_n = 1'b0;
      #2;
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), v);
         chk(v, 8'h00, 1, $sformatf("R1 rerst read offset %0d", a));
      end
      chk({4'h0, run_o, dir_o, ie_o, irq_o}, 8'h00, 1, "R1 rerst outputs");
      @(negedge clk); rst_n = 1'b1;

      done = 1'b1;
      summary();
      $finish;
   end
endmodule